// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block decides how long each external bus cycle lasts. The bus sequencer pulses a start strobe when it opens a cycle. From then on, the block raises a stall signal for every state time that must be added as a wait state. In the state where the cycle may finish, it raises a one-clock completion pulse. One clock of `clk` is one state time, and READY is looked at once per state time.

The number of wait states depends on three things: whether the access targets internal ROM, whether configuration has been loaded, and a three-bit ready-control field. Before configuration loads, every external cycle gets a fixed three wait states. After that, the field sets either a cap of zero to three waits or an unlimited mode that ends only on READY. When the READY pin is assigned to port use, the block sees READY as held low. In unlimited mode this hangs the bus, and the block reproduces that on purpose. A debug count shows how many waits the current or most recent cycle has received.

Top module: `ws_ctrl`

## Requirements
- R1: After a synchronous reset, `stall`, `cyc_done` and `wait_cnt` are 0, no cycle is in progress, and the block is back in the unconfigured state.
- R2: Until a `cfg_loaded` pulse has been seen (it takes effect for cycles accepted on later clocks), every external cycle gets exactly 3 wait states, whatever READY and `rdy_cfg` hold.
- R3: A cycle with `addr_internal`=1 gets no wait states. `cyc_done` is high in its first state and READY is ignored.
- R4: Once configured, `rdy_cfg` sets the cap as follows: 3'b000=0, 3'b001=1, 3'b010=2, 3'b011=3. The codes 3'b100 to 3'b110 act as a cap of 3.
- R5: In a capped mode, a state with effective READY low and fewer waits than the cap so far is a wait state. Waiting ends on the first state with READY high or once the cap is reached.
- R6: With `rdy_cfg`=3'b111, every state with effective READY low is a wait state, with no limit. The cycle ends in the first state with READY high.
- R7: When `rdy_pin_en`=0, effective READY is 0. In mode 3'b111 the block stalls for as long as the pin stays deselected. In capped modes the cycle runs to its cap.
- R8: A cycle with n wait states shows `stall` high for n states, then `cyc_done` high for exactly one clock with `stall` low. The clock after that is idle.
- R9: `wait_cnt` is 0 in the first state of each cycle and rises by one per wait state. It saturates at 3 and holds its value after the cycle ends.
- R10: A `cyc_start` that arrives while a cycle is in progress, including its completion state, is ignored.
- R11: `addr_internal` and `rdy_cfg` are captured when a cycle is accepted. Changing them during the cycle has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Bus cycle start strobe |
| addr_internal | input | 1 | 1 = access targets internal ROM |
| rdy_cfg | input | 3 | Ready-control field (cap or unlimited) |
| cfg_loaded | input | 1 | Pulse: configuration bytes fetched |
| rdy_pin_en | input | 1 | 1 = pin serves as READY, 0 = port pin |
| ready_pin | input | 1 | External READY pin |
| stall | output | 1 | Current state is a wait state |
| cyc_done | output | 1 | Cycle completes in this state |
| wait_cnt | output | 2 | Wait states inserted so far (saturating) |

## Verification
If the captured mode is wrong, the error shows at the ports in the first state after acceptance. `stall` and `cyc_done` are combinational in that mode, so a cycle that should be internal would stall, or a forced cycle would finish, on the very next clock. A counter that is off by one shows one clock later, as a `wait_cnt` step that does not match, or as a capped cycle ending one state early or late. A lost or sticky configuration flag shows up only on the next accepted external cycle, as a three-wait cycle where a capped one was expected, or the reverse.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int WCNT_W      = 2;
    localparam int CFG_W       = 3;
    localparam int FORCE_WAITS = 3;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_FORCED = 2'd1,
        MODE_CAPPED = 2'd2,
        MODE_OPEN   = 2'd3
    } ws_mode_e;

    typedef struct packed {
        ws_mode_e            mode;
        logic [WCNT_W-1:0]   cap;
    } ws_plan_t;

    function automatic ws_plan_t plan_cycle(
        input logic               internal,
        input logic               configured,
        input logic [CFG_W-1:0]   field
    );
        ws_plan_t p;
        p.mode = MODE_NONE;
        p.cap  = '0;
        if (internal) begin
            p.mode = MODE_NONE;
        end else if (!configured) begin
            p.mode = MODE_FORCED;
            p.cap  = WCNT_W'(FORCE_WAITS);
        end else if (&field) begin
            p.mode = MODE_OPEN;
            p.cap  = '1;
        end else begin
            p.mode = MODE_CAPPED;
            p.cap  = field[CFG_W-1] ? '1 : field[WCNT_W-1:0];
        end
        return p;
    endfunction

endpackage

// File: rtl/ws_plan_reg.sv
module ws_plan_reg
    import ws_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_loaded,
    input  logic            accept,
    input  logic            addr_internal,
    input  logic [CW-1:0]   rdy_cfg,
    output ws_plan_t        plan_q
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            plan_q <= '{mode: MODE_NONE, cap: '0};
        end else begin
            if (cfg_loaded) seen_q <= 1'b1;
            if (accept) plan_q <= plan_cycle(addr_internal, seen_q, rdy_cfg);
        end
    end
endmodule

// File: rtl/ws_counter.sv
module ws_counter #(
    parameter int W = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          inc,
    output logic [W-1:0]  cnt_q
);
    always_ff @(posedge clk) begin
        if (rst || clear)          cnt_q <= '0;
        else if (inc && !(&cnt_q)) cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/ws_ctrl.sv
module ws_ctrl
    import ws_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int NW = WCNT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_start,
    input  logic            addr_internal,
    input  logic [CW-1:0]   rdy_cfg,
    input  logic            cfg_loaded,
    input  logic            rdy_pin_en,
    input  logic            ready_pin,
    output logic            stall,
    output logic            cyc_done,
    output logic [NW-1:0]   wait_cnt
);
    logic     active_q;
    logic     accept;
    logic     rdy_eff;
    logic     need_wait;
    ws_plan_t plan_q;

    assign accept  = cyc_start && !active_q;
    assign rdy_eff = rdy_pin_en & ready_pin;

    ws_plan_reg #(.CW(CW)) u_plan (
        .clk(clk), .rst(rst), .cfg_loaded(cfg_loaded), .accept(accept),
        .addr_internal(addr_internal), .rdy_cfg(rdy_cfg), .plan_q(plan_q)
    );

    ws_counter #(.W(NW)) u_cnt (
        .clk(clk), .rst(rst), .clear(accept),
        .inc(active_q && need_wait), .cnt_q(wait_cnt)
    );

    always_comb begin
        unique case (plan_q.mode)
            MODE_FORCED: need_wait = wait_cnt < NW'(FORCE_WAITS);
            MODE_CAPPED: need_wait = !rdy_eff && (wait_cnt < plan_q.cap);
            MODE_OPEN:   need_wait = !rdy_eff;
            default:     need_wait = 1'b0;
        endcase
    end

    assign stall    = active_q && need_wait;
    assign cyc_done = active_q && !need_wait;

    always_ff @(posedge clk) begin
        if (rst)           active_q <= 1'b0;
        else if (accept)   active_q <= 1'b1;
        else if (cyc_done) active_q <= 1'b0;
    end
endmodule

// File: rtl/ws_ctrl_chk.sv
module ws_ctrl_chk
    import ws_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cyc_start,
    input logic        rdy_pin_en,
    input logic        ready_pin,
    input logic        stall,
    input logic        cyc_done,
    input logic [1:0]  wait_cnt,
    input logic        active,
    input ws_plan_t    plan
);
    a_r3_internal_no_stall: assert property (@(posedge clk) disable iff (rst)
        active && plan.mode == MODE_NONE |-> !stall && cyc_done);

    a_r2_forced_three: assert property (@(posedge clk) disable iff (rst)
        active && plan.mode == MODE_FORCED && wait_cnt < 2'd3 |-> stall);

    a_r5_cap_bound: assert property (@(posedge clk) disable iff (rst)
        active && plan.mode == MODE_CAPPED |-> wait_cnt <= plan.cap);

    a_r6_open_release: assert property (@(posedge clk) disable iff (rst)
        active && plan.mode == MODE_OPEN && rdy_pin_en && ready_pin |-> cyc_done);

    a_r7_pin_off_lockup: assert property (@(posedge clk) disable iff (rst)
        active && plan.mode == MODE_OPEN && !rdy_pin_en |-> stall);

    a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done && !stall);

    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        stall && wait_cnt < 2'd3 |=> wait_cnt == $past(wait_cnt) + 2'd1);

    a_r9_count_clear: assert property (@(posedge clk) disable iff (rst)
        !active && cyc_start |=> wait_cnt == 2'd0);

    a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
        active && cyc_start |=> $stable(plan));
endmodule

bind ws_ctrl ws_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .rdy_pin_en(rdy_pin_en),
    .ready_pin(ready_pin), .stall(stall), .cyc_done(cyc_done),
    .wait_cnt(wait_cnt), .active(active_q), .plan(plan_q)
);

// File: tb/ws_ctrl_test.sv
module ws_ctrl_test;
    logic clk = 1'b0;
    logic rst, cyc_start, addr_internal, cfg_loaded, rdy_pin_en, ready_pin;
    logic [2:0] rdy_cfg;
    logic stall, cyc_done;
    logic [1:0] wait_cnt;

    int n_chk = 0, n_bad = 0;
    string req = "R1";
    int m_act = 0, m_cnt = 0, m_seen = 0, m_mode = 0, m_cap = 0;
    logic obs_stall, obs_done;

    always #4 clk = ~clk;

    ws_ctrl uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .addr_internal(addr_internal),
        .rdy_cfg(rdy_cfg), .cfg_loaded(cfg_loaded), .rdy_pin_en(rdy_pin_en),
        .ready_pin(ready_pin), .stall(stall), .cyc_done(cyc_done), .wait_cnt(wait_cnt)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_need();
        int r;
        r = rdy_pin_en && ready_pin;
        if (!m_act) return 0;
        case (m_mode)
            1: return m_cnt < 3;
            2: return !r && m_cnt < m_cap;
            3: return !r;
            default: return 0;
        endcase
    endfunction

    task automatic tick();
        int need;
        #1;
        need = m_need();
        check("stall", int'(stall), (m_act != 0 && need != 0) ? 1 : 0);
        check("cyc_done", int'(cyc_done), (m_act != 0 && need == 0) ? 1 : 0);
        check("wait_cnt", int'(wait_cnt), m_cnt);
        obs_stall = stall;
        obs_done  = cyc_done;
        @(posedge clk);
        if (rst) begin
            m_act = 0; m_cnt = 0; m_seen = 0; m_mode = 0;
        end else begin
            if (!m_act && cyc_start) begin
                m_act = 1; m_cnt = 0;
                if (addr_internal) m_mode = 0;
                else if (m_seen == 0) m_mode = 1;
                else if (rdy_cfg == 3'd7) m_mode = 3;
                else begin m_mode = 2; m_cap = (rdy_cfg > 3) ? 3 : int'(rdy_cfg); end
            end else if (m_act) begin
                if (need != 0) m_cnt = (m_cnt < 3) ? m_cnt + 1 : 3;
                else m_act = 0;
            end
            if (cfg_loaded) m_seen = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_start = 0; cfg_loaded = 0; tick();
        end
    endtask

    task automatic run_cyc(input logic intl, input logic [2:0] f, input logic [2:0] f_after,
                           input logic pen, input int low_states, input logic hold,
                           input int exp_waits);
        int waits = 0, k = 0;
        addr_internal = intl; rdy_cfg = f; rdy_pin_en = pen; cyc_start = 1;
        ready_pin = 1; cfg_loaded = 0;
        tick();
        forever begin
            cyc_start = hold; rdy_cfg = f_after; addr_internal = ~intl;
            ready_pin = (k >= low_states);
            tick();
            k++;
            if (obs_stall) waits++;
            if (obs_done || k > 60) break;
        end
        cyc_start = 0;
        check("waits per cycle", waits, exp_waits);
        idle(1);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; cyc_start = 0; addr_internal = 0; rdy_cfg = 0;
        cfg_loaded = 0; rdy_pin_en = 1; ready_pin = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        req = "R1"; idle(2);
        req = "R2"; run_cyc(0, 3'd0, 3'd0, 1, 0, 0, 3);
        req = "R2"; run_cyc(0, 3'd7, 3'd7, 1, 20, 0, 3);
        req = "R3"; run_cyc(1, 3'd3, 3'd3, 1, 20, 0, 0);
        req = "R2"; cfg_loaded = 1; tick(); cfg_loaded = 0;
        req = "R4"; run_cyc(0, 3'd0, 3'd0, 1, 20, 0, 0);
        req = "R4"; run_cyc(0, 3'd1, 3'd1, 1, 20, 0, 1);
        req = "R4"; run_cyc(0, 3'd2, 3'd2, 1, 20, 0, 2);
        req = "R4"; run_cyc(0, 3'd3, 3'd3, 1, 20, 0, 3);
        req = "R4"; run_cyc(0, 3'd5, 3'd5, 1, 20, 0, 3);
        req = "R5"; run_cyc(0, 3'd6, 3'd6, 1, 1, 0, 1);
        req = "R5"; run_cyc(0, 3'd3, 3'd3, 1, 2, 0, 2);
        req = "R6"; run_cyc(0, 3'd7, 3'd7, 1, 6, 0, 6);
        req = "R6"; run_cyc(0, 3'd7, 3'd7, 1, 0, 0, 0);
        req = "R9"; run_cyc(0, 3'd7, 3'd7, 1, 9, 0, 9);
        req = "R7"; run_cyc(0, 3'd2, 3'd2, 0, 0, 0, 2);
        req = "R10"; run_cyc(0, 3'd1, 3'd1, 1, 20, 1, 1);
        req = "R11"; run_cyc(0, 3'd3, 3'd0, 1, 20, 0, 3);
        req = "R8"; run_cyc(0, 3'd2, 3'd2, 1, 20, 0, 2);
        req = "R7";
        addr_internal = 0; rdy_cfg = 3'd7; rdy_pin_en = 0; ready_pin = 1; cyc_start = 1;
        tick(); cyc_start = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            check("lockup stall", int'(obs_stall), 1);
        end
        req = "R1"; rst = 1; rdy_pin_en = 1; tick(); rst = 0; idle(1);
        req = "R1"; run_cyc(0, 3'd0, 3'd0, 1, 0, 0, 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule